// File: doc/BRIEF.md
# Multi-Channel DMA Request Controller

This block keeps the programmable state of a small set of DMA channels and turns transfer requests from devices into burst descriptors for a memory-side engine. Each channel owns four 32-bit words: a general storage word, a control/status word, a remaining byte count and a start address. Software reads and writes these words through a simple single-cycle register port. A device asks for service by presenting a channel number, a direction and a wanted length. The block checks that the channel is enabled and set up for that direction, and clamps the length to the remaining count. It then hands one descriptor (address, length, direction) downstream. When the downstream side takes the descriptor, the block decrements the count and flags terminal count.

A rejected request produces no descriptor. Instead it sets a memory-error status bit in the channel's control word and a sticky per-channel bit in a shared interrupt-source word. The requester is told the outcome by a one-cycle completion pulse carrying the granted length or an error flag. Data movement and address translation belong to the downstream engine.

The request input and the descriptor output are valid/ready streams. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high only while no request is in flight, so the block handles one request at a time. The descriptor is held unchanged while `burst_ready` is low, for as many cycles as the engine stalls.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel word and the interrupt-source word read as zero, `req_ready` is high and `burst_valid` and `done_valid` are low.
- R2: Channel c, word k (k = 0 storage, 1 control/status, 2 count, 3 address) sits at byte offset 0x100 + 32*c + 8*k and is fully read/write. Offsets with non-zero bits [2:0], channels at or above NUM_CH, and all other unmapped offsets read zero, and writes to them change nothing.
- R3: When a request is accepted, control bits 8, 9 and 10 of that channel are cleared before the outcome is recorded.
- R4: Control bit 0 enables a channel, and control bit 1 set means memory-to-device. A request is rejected if the channel is disabled, or if `req_to_mem`=1 while bit 1 is set, or if `req_to_mem`=0 while bit 1 is clear. A rejected request sets control bit 9 and interrupt bit c, issues no descriptor, and gives a completion pulse with `done_err`=1 and `done_len`=0 in the cycle after acceptance.
- R5: An accepted valid request drives a descriptor whose address is the channel's address word, whose length is min(`req_len`, count word), and whose direction equals `req_to_mem`. This happens in the cycle after acceptance.
- R6: On the descriptor handshake, control bit 8 is set and the count word drops by the granted length. The address word is left unchanged.
- R7: The interrupt-source word at offset 0x200 holds one bit per channel (bit c for channel c). Bits from different channels accumulate, stay set until reset, and ignore writes.
- R8: `req_ready` is high only when idle. While `burst_valid` is high and `burst_ready` low, the descriptor holds its values.
- R9: One cycle after the descriptor handshake, `done_valid` pulses for exactly one cycle with `done_err`=0 and `done_len` equal to the granted length.
- R10: A software write in the same cycle as a hardware update of the same channel word wins for that word. Hardware updates to the other words of that channel still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Device request valid |
| req_ready | output | 1 | Block can accept a request |
| req_ch | input | CH_W | Requested channel |
| req_to_mem | input | 1 | 1: device-to-memory, 0: memory-to-device |
| req_len | input | 32 | Requested byte length |
| burst_valid | output | 1 | Descriptor valid |
| burst_ready | input | 1 | Downstream takes descriptor |
| burst_addr | output | 32 | Descriptor start address |
| burst_len | output | 32 | Descriptor granted length |
| burst_to_mem | output | 1 | Descriptor direction |
| done_valid | output | 1 | One-cycle completion pulse |
| done_len | output | 32 | Granted length, zero on error |
| done_err | output | 1 | Request was rejected |

## Verification
Software register writes and hardware status/count updates can hit the same channel word in the same cycle. This happens at request acceptance (status clear and error set) and at the descriptor handshake (count decrement and terminal count). The bench provokes both cases on purpose. It raises `reg_wr` to a channel's count word in the cycle `burst_ready` completes a handshake. It also writes a control word in the cycle a rejected request on that channel is accepted. It then reads back every word of the channel and expects the written value in the targeted word, the hardware update in the untouched words, and the interrupt bit set regardless.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 10;

  localparam int IDX_STORE = 0;
  localparam int IDX_CTRL  = 1;
  localparam int IDX_COUNT = 2;
  localparam int IDX_ADDR  = 3;

  localparam int B_ENABLE = 0;
  localparam int B_M2D    = 1;
  localparam int B_TC     = 8;
  localparam int B_MERR   = 9;
  localparam int B_AERR   = 10;

  localparam logic [WORD_W-1:0] TC_BIT      = WORD_W'(1) << B_TC;
  localparam logic [WORD_W-1:0] MERR_BIT    = WORD_W'(1) << B_MERR;
  localparam logic [WORD_W-1:0] AERR_BIT    = WORD_W'(1) << B_AERR;
  localparam logic [WORD_W-1:0] STATUS_MASK = TC_BIT | MERR_BIT | AERR_BIT;

  localparam logic [OFS_W-1:0] IRQ_OFS = 10'h200;

  typedef struct packed {
    logic       hit_ch;
    logic       hit_irq;
    logic [2:0] ch;
    logic [1:0] idx;
  } dec_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_DONE  = 2'd2
  } state_t;

  function automatic dec_t decode(input logic [OFS_W-1:0] ofs, input int nch);
    dec_t d;
    d.ch      = ofs[7:5];
    d.idx     = ofs[4:3];
    d.hit_ch  = (ofs[9:8] == 2'b01) && (ofs[2:0] == 3'b000) && (int'(ofs[7:5]) < nch);
    d.hit_irq = (ofs == IRQ_OFS);
    return d;
  endfunction
endpackage

// File: rtl/dma_cc_regs.sv
module dma_cc_regs
  import dma_cc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  dec_t                           dec,
  input  logic [WORD_W-1:0]              wdata,
  input  logic                           acc_fire,
  input  logic [CH_W-1:0]                acc_ch,
  input  logic                           acc_err,
  input  logic                           tc_fire,
  input  logic [CH_W-1:0]                tc_ch,
  input  logic [WORD_W-1:0]              tc_len,
  output logic [NUM_CH-1:0]              en_o,
  output logic [NUM_CH-1:0]              m2d_o,
  output logic [NUM_CH-1:0][WORD_W-1:0]  cnt_o,
  output logic [NUM_CH-1:0][WORD_W-1:0]  adr_o,
  output logic [NUM_CH-1:0]              irq_o,
  output logic [WORD_W-1:0]              ch_rdata
);
  logic [NUM_CH-1:0][WORD_W-1:0] sto_w;
  logic [NUM_CH-1:0][WORD_W-1:0] ctl_w;
  logic [NUM_CH-1:0]             irq_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              sel, acc_me, tc_me;
    logic [WORD_W-1:0] sto_q, ctl_q, cnt_q, adr_q;

    assign sel    = wr_en && dec.hit_ch && (dec.ch == 3'(c));
    assign acc_me = acc_fire && (acc_ch == CH_W'(c));
    assign tc_me  = tc_fire && (tc_ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sto_q <= '0;
        ctl_q <= '0;
        cnt_q <= '0;
        adr_q <= '0;
      end else begin
        if (sel && dec.idx == 2'(IDX_STORE)) sto_q <= wdata;

        // software write outranks the hardware status update
        if (sel && dec.idx == 2'(IDX_CTRL))
          ctl_q <= wdata;
        else if (acc_me)
          ctl_q <= (ctl_q & ~STATUS_MASK) | (acc_err ? MERR_BIT : '0);
        else if (tc_me)
          ctl_q <= ctl_q | TC_BIT;

        if (sel && dec.idx == 2'(IDX_COUNT))
          cnt_q <= wdata;
        else if (tc_me)
          cnt_q <= cnt_q - tc_len;

        if (sel && dec.idx == 2'(IDX_ADDR)) adr_q <= wdata;
      end
    end

    assign sto_w[c] = sto_q;
    assign ctl_w[c] = ctl_q;
    assign cnt_o[c] = cnt_q;
    assign adr_o[c] = adr_q;
    assign en_o[c]  = ctl_q[B_ENABLE];
    assign m2d_o[c] = ctl_q[B_M2D];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else if (acc_fire && acc_err) irq_q <= irq_q | (NUM_CH'(1) << acc_ch);
  end
  assign irq_o = irq_q;

  always_comb begin
    ch_rdata = '0;
    if (dec.hit_ch) begin
      unique case (dec.idx)
        2'(IDX_STORE): ch_rdata = sto_w[dec.ch[CH_W-1:0]];
        2'(IDX_CTRL):  ch_rdata = ctl_w[dec.ch[CH_W-1:0]];
        2'(IDX_COUNT): ch_rdata = cnt_o[dec.ch[CH_W-1:0]];
        default:       ch_rdata = adr_o[dec.ch[CH_W-1:0]];
      endcase
    end
  end
endmodule

// File: rtl/dma_cc_ctrl.sv
module dma_cc_ctrl
  import dma_cc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [CH_W-1:0]               req_ch,
  input  logic                          req_to_mem,
  input  logic [WORD_W-1:0]             req_len,
  output logic                          burst_valid,
  input  logic                          burst_ready,
  output logic [WORD_W-1:0]             burst_addr,
  output logic [WORD_W-1:0]             burst_len,
  output logic                          burst_to_mem,
  output logic                          done_valid,
  output logic [WORD_W-1:0]             done_len,
  output logic                          done_err,
  input  logic [NUM_CH-1:0]             en_i,
  input  logic [NUM_CH-1:0]             m2d_i,
  input  logic [NUM_CH-1:0][WORD_W-1:0] cnt_i,
  input  logic [NUM_CH-1:0][WORD_W-1:0] adr_i,
  output logic                          acc_fire,
  output logic [CH_W-1:0]               acc_ch,
  output logic                          acc_err,
  output logic                          tc_fire,
  output logic [CH_W-1:0]               tc_ch,
  output logic [WORD_W-1:0]             tc_len
);
  state_t            st_q;
  logic [CH_W-1:0]   ch_q;
  logic [WORD_W-1:0] addr_q, len_q, dlen_q;
  logic              dir_q, derr_q;
  logic [WORD_W-1:0] cnt_sel, grant;

  assign req_ready = (st_q == ST_IDLE);
  assign acc_fire  = req_valid && req_ready;
  assign acc_ch    = req_ch;
  // mode bit set means memory-to-device, so a device-to-memory request needs it clear
  assign acc_err   = !en_i[req_ch] || (req_to_mem == m2d_i[req_ch]);
  assign cnt_sel   = cnt_i[req_ch];
  assign grant     = (req_len < cnt_sel) ? req_len : cnt_sel;

  assign tc_fire = (st_q == ST_BURST) && burst_ready;
  assign tc_ch   = ch_q;
  assign tc_len  = len_q;

  assign burst_valid  = (st_q == ST_BURST);
  assign burst_addr   = addr_q;
  assign burst_len    = len_q;
  assign burst_to_mem = dir_q;
  assign done_valid   = (st_q == ST_DONE);
  assign done_len     = dlen_q;
  assign done_err     = derr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      addr_q <= '0;
      len_q  <= '0;
      dir_q  <= 1'b0;
      dlen_q <= '0;
      derr_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (acc_fire) begin
            ch_q <= req_ch;
            if (acc_err) begin
              derr_q <= 1'b1;
              dlen_q <= '0;
              st_q   <= ST_DONE;
            end else begin
              addr_q <= adr_i[req_ch];
              len_q  <= grant;
              dir_q  <= req_to_mem;
              st_q   <= ST_BURST;
            end
          end
        end
        ST_BURST: begin
          if (burst_ready) begin
            dlen_q <= len_q;
            derr_q <= 1'b0;
            st_q   <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_cc_pkg::*;
#(
  parameter  int NUM_CH = 4,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_ch,
  input  logic              req_to_mem,
  input  logic [WORD_W-1:0] req_len,
  output logic              burst_valid,
  input  logic              burst_ready,
  output logic [WORD_W-1:0] burst_addr,
  output logic [WORD_W-1:0] burst_len,
  output logic              burst_to_mem,
  output logic              done_valid,
  output logic [WORD_W-1:0] done_len,
  output logic              done_err
);
  dec_t                          dec;
  logic [NUM_CH-1:0]             en_w, m2d_w, irq_bits;
  logic [NUM_CH-1:0][WORD_W-1:0] cnt_w, adr_w;
  logic                          acc_fire, acc_err, tc_fire;
  logic [CH_W-1:0]               acc_ch, tc_ch;
  logic [WORD_W-1:0]             tc_len, ch_rdata;

  assign dec       = decode(reg_addr, NUM_CH);
  assign reg_rdata = dec.hit_irq ? WORD_W'(irq_bits) : ch_rdata;

  dma_cc_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .dec      (dec),
    .wdata    (reg_wdata),
    .acc_fire (acc_fire),
    .acc_ch   (acc_ch),
    .acc_err  (acc_err),
    .tc_fire  (tc_fire),
    .tc_ch    (tc_ch),
    .tc_len   (tc_len),
    .en_o     (en_w),
    .m2d_o    (m2d_w),
    .cnt_o    (cnt_w),
    .adr_o    (adr_w),
    .irq_o    (irq_bits),
    .ch_rdata (ch_rdata)
  );

  dma_cc_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_ch       (req_ch),
    .req_to_mem   (req_to_mem),
    .req_len      (req_len),
    .burst_valid  (burst_valid),
    .burst_ready  (burst_ready),
    .burst_addr   (burst_addr),
    .burst_len    (burst_len),
    .burst_to_mem (burst_to_mem),
    .done_valid   (done_valid),
    .done_len     (done_len),
    .done_err     (done_err),
    .en_i         (en_w),
    .m2d_i        (m2d_w),
    .cnt_i        (cnt_w),
    .adr_i        (adr_w),
    .acc_fire     (acc_fire),
    .acc_ch       (acc_ch),
    .acc_err      (acc_err),
    .tc_fire      (tc_fire),
    .tc_ch        (tc_ch),
    .tc_len       (tc_len)
  );
endmodule

// File: rtl/dma_cc_chk.sv
module dma_cc_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              burst_valid,
  input logic              burst_ready,
  input logic [31:0]       burst_addr,
  input logic [31:0]       burst_len,
  input logic              burst_to_mem,
  input logic              done_valid,
  input logic [31:0]       done_len,
  input logic              done_err,
  input logic [NUM_CH-1:0] irq_bits
);
  assert_burst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !burst_ready |=> burst_valid && $stable(burst_addr)
                                    && $stable(burst_len) && $stable(burst_to_mem));

  assert_single_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !burst_valid && !done_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_done_follows_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && burst_ready |=> done_valid && !done_err);

  assert_err_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_err |-> done_len == 32'd0 && $past(req_valid && req_ready));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_bits & $past(irq_bits)) == $past(irq_bits));
endmodule

bind dma_chan_ctrl dma_cc_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .burst_valid  (burst_valid),
  .burst_ready  (burst_ready),
  .burst_addr   (burst_addr),
  .burst_len    (burst_len),
  .burst_to_mem (burst_to_mem),
  .done_valid   (done_valid),
  .done_len     (done_len),
  .done_err     (done_err),
  .irq_bits     (irq_bits)
);

// File: tb/tb_dma_chan_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_ch = '0;
  logic        req_to_mem = 1'b0;
  logic [31:0] req_len = '0;
  logic        burst_valid;
  logic        burst_ready = 1'b0;
  logic [31:0] burst_addr, burst_len;
  logic        burst_to_mem;
  logic        done_valid;
  logic [31:0] done_len;
  logic        done_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] m [4][4];
  logic [3:0]  m_irq;

  always #2 clk = ~clk;

  dma_chan_ctrl #(.NUM_CH(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_ch(req_ch), .req_to_mem(req_to_mem),
    .req_len(req_len), .burst_valid(burst_valid), .burst_ready(burst_ready),
    .burst_addr(burst_addr), .burst_len(burst_len), .burst_to_mem(burst_to_mem),
    .done_valid(done_valid), .done_len(done_len), .done_err(done_err)
  );

  function automatic logic [9:0] ofs(input int ch, input int idx);
    return 10'(10'h100 + ch * 32 + idx * 8);
  endfunction

  function automatic bit maps(input logic [9:0] a);
    return (a[9:8] == 2'b01) && (a[2:0] == 3'b000) && (a[7:5] < 3'd4);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    if (a == 10'h200) return {28'b0, m_irq};
    if (maps(a)) return m[a[6:5]][a[4:3]];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [9:0] a);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp_rd(a));
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (maps(a)) m[a[6:5]][a[4:3]] = d;
  endtask

  task automatic readback(input string tag, input int ch);
    for (int k = 0; k < 4; k++) rd(tag, ofs(ch, k));
    rd(tag, 10'h200);
  endtask

  task automatic do_req(input int ch, input bit tm, input logic [31:0] len, input int stall);
    logic [31:0] c, g;
    bit bad;
    @(negedge clk);
    chk("R8 ready when idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_ch = 2'(ch); req_to_mem = tm; req_len = len;
    c   = m[ch][1];
    bad = !c[0] || (tm == c[1]);
    g   = (len < m[ch][2]) ? len : m[ch][2];
    m[ch][1] = c & ~32'h700;   // R3 status cleared on acceptance
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      m[ch][1] = m[ch][1] | 32'h200;
      m_irq = m_irq | (4'b1 << ch);
      chk("R4 no descriptor", {31'b0, burst_valid}, 32'd0);
      chk("R4 done on error", {31'b0, done_valid}, 32'd1);
      chk("R4 error flag", {31'b0, done_err}, 32'd1);
      chk("R4 error length", done_len, 32'd0);
    end else begin
      for (int i = 0; i < stall; i++) begin
        chk("R8 held under stall", {31'b0, burst_valid}, 32'd1);
        chk("R8 addr held", burst_addr, m[ch][3]);
        @(negedge clk);
      end
      chk("R5 descriptor valid", {31'b0, burst_valid}, 32'd1);
      chk("R5 descriptor addr", burst_addr, m[ch][3]);
      chk("R5 descriptor len", burst_len, g);
      chk("R5 descriptor dir", {31'b0, burst_to_mem}, {31'b0, tm});
      chk("R8 busy not ready", {31'b0, req_ready}, 32'd0);
      burst_ready = 1'b1;
      @(negedge clk);
      burst_ready = 1'b0;
      m[ch][1] = m[ch][1] | 32'h100;
      m[ch][2] = m[ch][2] - g;
      chk("R9 done pulse", {31'b0, done_valid}, 32'd1);
      chk("R9 done no error", {31'b0, done_err}, 32'd0);
      chk("R9 done length", done_len, g);
    end
    @(negedge clk);
    chk("R9 done single cycle", {31'b0, done_valid}, 32'd0);
    readback("R6 R3 channel words after request", ch);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) for (int k = 0; k < 4; k++) m[c][k] = '0;
    m_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1 no descriptor", {31'b0, burst_valid}, 32'd0);
    chk("R1 no done", {31'b0, done_valid}, 32'd0);
    for (int c = 0; c < 4; c++) readback("R1 reset words", c);

    // R2 mapping, storage word and ignored offsets
    wr(ofs(0, 0), 32'hA5A5_0001);
    wr(ofs(3, 3), 32'h1234_5678);
    rd("R2 storage word", ofs(0, 0));
    rd("R2 address word ch3", ofs(3, 3));
    wr(10'h104, 32'hFFFF_FFFF);
    rd("R2 misaligned write ignored", ofs(0, 0));
    rd("R2 misaligned read zero", 10'h104);
    wr(10'h180, 32'hDEAD_BEEF);
    rd("R2 absent channel zero", 10'h180);
    rd("R2 unmapped zero", 10'h3F8);

    // R4 disabled channel, then direction mismatch on channel 1
    do_req(0, 1'b1, 32'd16, 0);
    wr(ofs(1, 1), 32'h0000_0003);
    wr(ofs(1, 2), 32'd40);
    do_req(1, 1'b1, 32'd8, 0);
    // R7 bits from two channels accumulate; writes ignored
    wr(10'h200, 32'h0);
    rd("R7 irq sticky and write ignored", 10'h200);

    // R5 R6 clamp to count, address unchanged, stall on descriptor (R8)
    do_req(1, 1'b0, 32'd100, 3);
    do_req(1, 1'b0, 32'd7, 1);
    // R3 stale status cleared on good request
    wr(ofs(2, 1), 32'h0000_0701);
    wr(ofs(2, 2), 32'd100);
    wr(ofs(2, 3), 32'h0000_4000);
    do_req(2, 1'b1, 32'd30, 0);
    chk("R3 status cleared then TC", m[2][1], 32'h0000_0101);
    // zero count still completes with length 0
    wr(ofs(0, 1), 32'h0000_0001);
    do_req(0, 1'b1, 32'd5, 0);

    // R10 software write to count during handshake
    @(negedge clk);
    req_valid = 1'b1; req_ch = 2'd2; req_to_mem = 1'b1; req_len = 32'd10;
    @(negedge clk);
    req_valid = 1'b0;
    burst_ready = 1'b1; reg_wr = 1'b1; reg_addr = ofs(2, 2); reg_wdata = 32'd500;
    @(negedge clk);
    burst_ready = 1'b0; reg_wr = 1'b0;
    m[2][1] = (m[2][1] & ~32'h700) | 32'h100;
    m[2][2] = 32'd500;
    chk("R10 done with count collision", done_len, 32'd10);
    @(negedge clk);
    readback("R10 write wins on count, TC still set", 2);

    // R10 software write to control during rejected acceptance
    @(negedge clk);
    req_valid = 1'b1; req_ch = 2'd3; req_to_mem = 1'b0; req_len = 32'd4;
    reg_wr = 1'b1; reg_addr = ofs(3, 1); reg_wdata = 32'h0000_0602;
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0;
    m[3][1] = 32'h0000_0602;
    m_irq = m_irq | 4'b1000;
    chk("R10 error done", {31'b0, done_err}, 32'd1);
    @(negedge clk);
    readback("R10 write wins on control, irq still set", 3);

    // random traffic
    for (int it = 0; it < 300; it++) begin
      int op, ch, k;
      logic [31:0] d;
      op = int'($urandom % 4);
      ch = int'($urandom % 4);
      if (op == 0) begin
        k = int'($urandom % 4);
        d = $urandom;
        if (k == 1) d = d & 32'h0000_0703;
        if (k == 2) d = d % 128;
        wr(ofs(ch, k), d);
        rd("R2 random write readback", ofs(ch, k));
      end else if (op == 1) begin
        wr(10'(ofs(ch, 0) + 10'($urandom % 8)), $urandom);
        rd("R2 random aligned storage", ofs(ch, 0));
      end else begin
        do_req(ch, 1'($urandom), $urandom % 96, int'($urandom % 3));
      end
    end
    rd("R7 final irq", 10'h200);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule